// File: doc/BRIEF.md
# Sampled XOR Phase Comparator with Per-Period Phase Word

This block compares a reference square wave with a feedback square wave, both sampled by a fast system clock. Each input is first retimed through its own two-stage synchroniser. The two retimed signals then drive an exclusive-OR, and that raw pulse train is exported as `xor_out` for an external filter.

Alongside the raw pulse train, the block measures the pulse train's duty over each reference period. A period runs from one rising edge of the retimed reference to the next. When a period closes, the block divides the number of clocks that the XOR was high by the period length in clocks and scales the result to 0..180 degrees. It presents the result on `phase_word` with a one-clock `phase_valid` strobe.

The XOR method only gives a true reading for symmetric inputs, so the same window also times the reference high phase. The block raises `asym_flag` when that high phase is too far from half the period. The result side is a plain valid-only stream with no ready input. The consumer has no way to apply back-pressure, so it must take each word in the cycle its strobe is high. The word and the flag then hold until the next strobe.

Top module: `xor_phase_det`

## Requirements
- R1: When `ref_in` and `fb_in` are identical waveforms, `xor_out` stays low in every cycle and `phase_word` reads 0.
- R2: `xor_out` in any cycle equals `ref_in` XOR `fb_in` as sampled two rising clock edges earlier.
- R3: When `fb_in` is the inverse of a 50 % duty `ref_in`, `xor_out` stays high in every cycle and `phase_word` reads 180.
- R4: For a reference period of P clocks in which `xor_out` was high for K clocks, `phase_word` = floor(K*180/P).
- R5: `phase_valid` is a single-cycle pulse. It is high three rising clock edges after a rising edge is driven on `ref_in`. The first reference rising edge after reset only opens a window and produces no pulse.
- R6: For 50 % duty inputs a quarter period apart (90 degrees), `phase_word` reads 90.
- R7: For 50 % duty inputs offset by anything other than 0 or half a period, `xor_out` rises twice in each reference period.
- R8: `asym_flag` is set when |2*Hr - P| > 2*ASYM_TOL, where Hr is the reference high time in clocks, P is the period and ASYM_TOL defaults to 2. Otherwise it is clear.
- R9: `phase_word` and `asym_flag` change only with a `phase_valid` pulse.
- R10: While reset is asserted and right after it, `xor_out`, `phase_word`, `phase_valid` and `asym_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| xor_out | output | 1 | XOR of the two retimed inputs |
| phase_word | output | WORD_W (8) | Phase error, 0..180 degrees |
| phase_valid | output | 1 | One-clock strobe marking a new `phase_word` |
| asym_flag | output | 1 | Reference duty too far from 50 % |

## Verification
An input change reaches `xor_out` after two rising edges. The bench keeps a two-deep history of what it drove and compares `xor_out` against it at every falling edge. A measurement lands one edge after the retimed reference edge that closes its window, which puts `phase_valid` three edges after the driven input edge. The bench checks that latency directly and otherwise waits on the strobe itself. After every change of stimulus, the bench discards the first two strobes, because their windows straddle the change. It then takes the third strobe as the result. The XOR high cycles and rising edges counted between the second and third strobes give exactly one clean period to compare against.

// File: rtl/xpd_pkg.sv
package xpd_pkg;
  localparam int DEG_FULL = 180;
  localparam int DEG_W    = $clog2(DEG_FULL + 1);

  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/xpd_sync.sv
module xpd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else             chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xpd_window.sv
module xpd_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  input  logic             xor_s,
  output logic             close,
  output logic [CNT_W-1:0] per_cnt,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] rhi_cnt
);
  import xpd_pkg::*;
  localparam int unsigned LIM = (1 << CNT_W) - 1;

  logic ref_d, armed, rise;

  assign rise  = ref_s & ~ref_d;
  assign close = rise & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      armed   <= 1'b0;
      per_cnt <= '0;
      hi_cnt  <= '0;
      rhi_cnt <= '0;
    end else begin
      ref_d <= ref_s;
      if (rise) begin
        armed   <= 1'b1;
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(xor_s);
        rhi_cnt <= CNT_W'(1);
      end else begin
        per_cnt <= CNT_W'(sat_inc(int'(per_cnt), LIM));
        if (xor_s) hi_cnt  <= CNT_W'(sat_inc(int'(hi_cnt), LIM));
        if (ref_s) rhi_cnt <= CNT_W'(sat_inc(int'(rhi_cnt), LIM));
      end
    end
  end
endmodule

// File: rtl/xpd_scale.sv
module xpd_scale #(
  parameter int CNT_W    = 16,
  parameter int WORD_W   = 8,
  parameter int ASYM_TOL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic [CNT_W-1:0]  per_cnt,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [CNT_W-1:0]  rhi_cnt,
  output logic [WORD_W-1:0] phase_word,
  output logic              phase_valid,
  output logic              asym_flag
);
  import xpd_pkg::*;
  localparam int PROD_W = CNT_W + DEG_W;
  localparam int DIFF_W = CNT_W + 2;

  logic [PROD_W-1:0] prod, quot;
  logic [DIFF_W-1:0] twice_hi, per_ext, gap;
  logic              skewed;

  always_comb begin
    prod = PROD_W'(hi_cnt) * PROD_W'(DEG_FULL);
    quot = (per_cnt == '0) ? '0 : prod / PROD_W'(per_cnt);
  end

  always_comb begin
    twice_hi = DIFF_W'(rhi_cnt) << 1;
    per_ext  = DIFF_W'(per_cnt);
    gap      = (twice_hi >= per_ext) ? twice_hi - per_ext : per_ext - twice_hi;
    skewed   = gap > DIFF_W'(2 * ASYM_TOL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_word  <= '0;
      phase_valid <= 1'b0;
      asym_flag   <= 1'b0;
    end else begin
      phase_valid <= close;
      if (close) begin
        phase_word <= quot[WORD_W-1:0];
        asym_flag  <= skewed;
      end
    end
  end
endmodule

// File: rtl/xor_phase_det.sv
module xor_phase_det #(
  parameter int CNT_W    = 16,
  parameter int WORD_W   = xpd_pkg::DEG_W,
  parameter int ASYM_TOL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  output logic              xor_out,
  output logic [WORD_W-1:0] phase_word,
  output logic              phase_valid,
  output logic              asym_flag
);
  logic [1:0]       raw, synced;
  logic             close;
  logic [CNT_W-1:0] per_cnt, hi_cnt, rhi_cnt;

  assign raw = {fb_in, ref_in};

  xpd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign xor_out = synced[0] ^ synced[1];

  xpd_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_s(synced[0]), .xor_s(xor_out),
    .close(close), .per_cnt(per_cnt), .hi_cnt(hi_cnt), .rhi_cnt(rhi_cnt)
  );

  xpd_scale #(.CNT_W(CNT_W), .WORD_W(WORD_W), .ASYM_TOL(ASYM_TOL)) u_scale (
    .clk(clk), .rst_n(rst_n), .close(close),
    .per_cnt(per_cnt), .hi_cnt(hi_cnt), .rhi_cnt(rhi_cnt),
    .phase_word(phase_word), .phase_valid(phase_valid), .asym_flag(asym_flag)
  );
endmodule

// File: rtl/xpd_checker.sv
module xpd_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_in,
  input logic              fb_in,
  input logic              xor_out,
  input logic [WORD_W-1:0] phase_word,
  input logic              phase_valid,
  input logic              asym_flag
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_XOR_TRACKS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (xor_out == ($past(ref_in, 2) ^ $past(fb_in, 2)))); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |=> !phase_valid); // R5
  AST_WORD_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> (int'(phase_word) <= 180)); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid |-> $stable(phase_word)); // R9
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid |-> $stable(asym_flag)); // R9
endmodule

bind xor_phase_det xpd_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .xor_out(xor_out),
  .phase_word(phase_word), .phase_valid(phase_valid), .asym_flag(asym_flag)
);

// File: tb/xor_phase_det_tb_top.sv
`timescale 1ns/1ps
module xor_phase_det_tb_top;
  localparam int TOL = 2;
  localparam int NV  = 10;
  // columns: period, ref/fb high time, fb delay, expected phase word
  localparam int VEC [NV][4] = '{
    '{20, 10,  0,   0}, '{20, 10, 10, 180}, '{20, 10,  5,  90}, '{20, 10, 15,  90},
    '{36, 18,  1,  10}, '{30, 15,  7,  84}, '{14,  7,  3,  77}, '{20, 12,  0,   0},
    '{20, 13,  0,   0}, '{20, 14,  0,   0}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, fb_in = 1'b0;
  logic       xor_out, phase_valid, asym_flag;
  logic [7:0] phase_word;

  xor_phase_det dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .xor_out(xor_out),
    .phase_word(phase_word), .phase_valid(phase_valid), .asym_flag(asym_flag)
  );

  int n_chk = 0, n_bad = 0;
  int gp = 20, gh = 10, gd = 0, cyc = 0;
  bit run = 1'b0;
  logic man_ref = 1'b0, man_fb = 1'b0;
  logic h1r = 0, h1f = 0, h2r = 0, h2f = 0, xprev = 0;
  int hi_tot = 0, rise_tot = 0, r2_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (xor_out !== (h2r ^ h2f)) r2_err++;
      if (xor_out) hi_tot++;
      if (xor_out && !xprev) rise_tot++;
    end
    xprev = xor_out;
    h2r = h1r; h2f = h1f;
    if (run) begin
      ref_in = (cyc % gp) < gh;
      fb_in  = ((cyc + gp - gd) % gp) < gh;
      cyc++;
    end else begin
      ref_in = man_ref;
      fb_in  = man_fb;
    end
    h1r = ref_in; h1f = fb_in;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got, input bit hold_chk, input int held);
    got = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1;
      if (phase_valid) begin got = 1'b1; return; end
      if (hold_chk && int'(phase_word) != held)
        chk(1'b0, "R9 word held", int'(phase_word), held);
    end
  endtask

  task automatic run_vec(input int p, input int h, input int d, input int xw);
    bit got;
    int hi0, r0, e0, w0, xhi, xr, xa;
    @(posedge clk); #1;
    gp = p; gh = h; gd = d; cyc = 0; run = 1'b1;
    wait_valid(got, 1'b0, 0);
    wait_valid(got, 1'b0, 0);
    hi0 = hi_tot; r0 = rise_tot; e0 = r2_err; w0 = int'(phase_word);
    wait_valid(got, 1'b1, w0);
    chk(got, "R5 strobe present", int'(got), 1);
    xhi = (d == 0) ? 0 : (((d % p) <= p / 2) ? 2 * (d % p) : 2 * (p - (d % p)));
    xr  = (xhi == 0 || xhi == p) ? 0 : 2;
    xa  = (((2 * h > p) ? 2 * h - p : p - 2 * h) > 2 * TOL) ? 1 : 0;
    chk(int'(phase_word) == xw, (d == 0) ? "R1 word in phase" :
        (xhi == p) ? "R3 word antiphase" : (xw == 90) ? "R6 word quadrature" : "R4 word",
        int'(phase_word), xw);
    chk(hi_tot - hi0 == xhi, (d == 0) ? "R1 xor high cycles" : (xhi == p) ?
        "R3 xor high cycles" : "R4 xor high cycles", hi_tot - hi0, xhi);
    chk(rise_tot - r0 == xr, "R7 xor rises per period", rise_tot - r0, xr);
    chk(int'(asym_flag) == xa, "R8 asym flag", int'(asym_flag), xa);
    chk(r2_err == e0, "R2 xor latency", r2_err - e0, 0);
    @(negedge clk); #1;
    chk(!phase_valid, "R5 single-cycle strobe", int'(phase_valid), 0);
  endtask

  task automatic do_reset();
    run = 1'b0; man_ref = 1'b0; man_fb = 1'b0;
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk(!xor_out && !phase_valid && !asym_flag && phase_word == 0, "R10 reset outputs",
        int'({xor_out, phase_valid, asym_flag}) + int'(phase_word), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!xor_out && !phase_valid && !asym_flag && phase_word == 0, "R10 after release",
        int'({xor_out, phase_valid, asym_flag}) + int'(phase_word), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seen, at;
    do_reset();
    // R5: first reference edge only arms the window
    repeat (20) @(posedge clk);
    #1 man_ref = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); #1; if (phase_valid) seen++; end
    chk(seen == 0, "R5 no strobe on first edge", seen, 0);
    @(posedge clk); #1 man_ref = 1'b0;
    repeat (20) @(posedge clk);
    #1 man_ref = 1'b1;
    at = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk); #1;
      if (phase_valid && at == 0) at = i;
    end
    chk(at == 4, "R5 strobe three edges after input", at, 4);

    for (int v = 0; v < NV; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    do_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule